// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address to a physical frame when a translation cache misses. It walks a two-level structure held in memory. The first level is a directory of 1024 four-byte entries, indexed by address bits 31:22. The second level is a page table of 1024 four-byte entries, indexed by bits 21:12. Each address space is named by a 7-bit identifier, and the block holds one directory base per identifier.

Software loads a directory base in two writes. The first write selects the identifier and the second writes the base word. The walker reads entries through a one-word request/response memory port and handles one walk at a time. It returns either a frame number with read, write and non-secure attributes, or a fault. A fault is either a translation fault or a permission fault.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req_valid` are 0, and no identifier has a directory base.
- R2: A configuration write with `cfg_sel_data`=0 latches `cfg_wdata[6:0]` as the selected identifier. A later write with `cfg_sel_data`=1 stores `cfg_wdata[FN_W-1:0]` as that identifier's directory frame. Only the most recent selection counts, and other identifiers keep their state.
- R3: A walk for an identifier whose base was never written ends with a translation fault (`rsp_fault`=1, `rsp_perm`=0). No memory read is made, and `rsp_valid` is high in cycle 1 after the accept edge.
- R4: The directory entry is read at `base*4096 + va[31:22]*4`. The table entry is then read at `tbl*4096 + va[21:12]*4`, where `tbl` is directory entry bits FN_W-1:0.
- R5: A directory entry that is all zero, or that has bit 28 clear, ends the walk with a translation fault after one memory read. Every fault reports frame 0 and all attributes 0.
- R6: A table entry that is all zero ends the walk with a translation fault.
- R7: A write request (`req_write`=1) to an entry with bit 30 clear, or a read request to an entry with bit 31 clear, ends with a permission fault (`rsp_fault`=1, `rsp_perm`=1).
- R8: A successful walk returns `rsp_frame` = table entry bits FN_W-1:0, with `rsp_rd`, `rsp_wr` and `rsp_ns` taken from entry bits 31, 30 and 29, and `rsp_fault`=0.
- R9: Bits at or above FN_W in the base word, the directory entry and the table entry (below bit 28 or 29) do not affect any address or frame.
- R10: With a memory latency of L, `rsp_valid` is a one-cycle pulse. It is high in cycle 2L+3 after the accept edge for a two-read walk, and in cycle L+2 for a walk ended by the directory entry.
- R11: `busy` is high from the cycle after the accept edge through the `rsp_valid` cycle, and low after it. A request presented while busy is ignored.
- R12: `mem_req_valid` is a one-cycle pulse with at most one read outstanding, so a walk makes at most two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel_data | input | 1 | 0: identifier select write, 1: base data write |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Walk request, taken when not busy |
| req_asid | input | ASID_W | Address space identifier of the request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| busy | output | 1 | Walk in progress; requests are ignored |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | PA_BITS | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Memory read data valid |
| mem_resp_data | input | 32 | Memory read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_frame | output | PA_BITS-12 | Physical frame number |
| rsp_rd | output | 1 | Page readable |
| rsp_wr | output | 1 | Page writable |
| rsp_ns | output | 1 | Page non-secure |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_perm | output | 1 | Fault is a permission fault (else translation) |

## Verification
Each result arrives in a cycle fixed by the memory latency. An unprogrammed identifier answers in cycle 1 after the accept edge, a directory-level fault in cycle L+2, and a full walk in cycle 2L+3. The bench counts clock cycles from the accept edge to the first `rsp_valid` and compares the count with those formulas. It runs with latencies of 1 and 3. The memory model answers L falling edges after it sees a request. It samples and drives only on falling edges, so each read returns on the rising edge the formula expects. The bench checks `busy` one cycle after the result and counts the memory reads of each walk.

// File: rtl/xw_pkg.sv
// Shared constants and types for the two-level walker.
// Assumes 32-bit virtual addresses, 4 KiB pages and 1024-entry levels.
package xw_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 10;
    localparam int VPN_W      = 32 - PAGE_SHIFT;
    localparam int BIT_RD     = 31;
    localparam int BIT_WR     = 30;
    localparam int BIT_NS     = 29;
    localparam int BIT_NEXT   = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_DONE
    } xw_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ns;
    } xw_attr_t;
endpackage

// File: rtl/xw_base_table.sv
// Per-identifier directory base store, loaded by a select write followed
// by a data write. Assumes a data write refers to the latest selection.
module xw_base_table #(
    parameter int ASID_W = 7,
    parameter int FN_W   = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel_data,
    input  logic [31:0]       cfg_wdata,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [FN_W-1:0]   lk_base,
    output logic              lk_valid
);
    localparam int NUM_ASID = 1 << ASID_W;

    logic [ASID_W-1:0]   sel_q;
    logic [FN_W-1:0]     base_mem [NUM_ASID];
    logic [NUM_ASID-1:0] valid_q;

    // Latch the selected identifier on a select write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (cfg_wr && !cfg_sel_data)
            sel_q <= cfg_wdata[ASID_W-1:0];
    end

    // Store the masked directory frame for the selected identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < NUM_ASID; i++)
                base_mem[i] <= '0;
        end else if (cfg_wr && cfg_sel_data) begin
            base_mem[sel_q] <= cfg_wdata[FN_W-1:0];
            valid_q[sel_q]  <= 1'b1;
        end
    end

    // Lookup port for the walker.
    always_comb begin
        lk_base  = base_mem[lk_asid];
        lk_valid = valid_q[lk_asid];
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel_data) |=> $stable(sel_q)); // R2
    AST_DATA_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel_data) |=> valid_q[$past(sel_q)]); // R2
endmodule

// File: rtl/xw_entry_decode.sv
// Decodes one 32-bit directory or table entry into its fields.
// Assumes the frame field fits below the next-level flag (FN_W <= 28).
module xw_entry_decode
    import xw_pkg::*;
#(
    parameter int FN_W = 22
) (
    input  logic [31:0]     entry,
    output logic            is_zero,
    output logic            has_next,
    output xw_attr_t        attr,
    output logic [FN_W-1:0] frame
);
    // Split the entry word into flags, attributes and masked frame.
    always_comb begin
        is_zero  = (entry == 32'd0);
        has_next = entry[BIT_NEXT];
        attr.rd  = entry[BIT_RD];
        attr.wr  = entry[BIT_WR];
        attr.ns  = entry[BIT_NS];
        frame    = entry[FN_W-1:0];
    end

    always_comb begin
        AST_FRAME_FITS: assert (FN_W <= BIT_NEXT); // R9
    end
endmodule

// File: rtl/xw_walk_fsm.sv
// Sequencer for a single walk: directory read, table read, decode checks
// and result. Assumes memory returns exactly one response per request.
module xw_walk_fsm
    import xw_pkg::*;
#(
    parameter int FN_W = 22,
    localparam int PA_W = FN_W + PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             base_valid,
    input  logic [FN_W-1:0]  base_frame,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_resp_valid,
    input  logic             dec_zero,
    input  logic             dec_next,
    input  xw_attr_t         dec_attr,
    input  logic [FN_W-1:0]  dec_frame,
    output logic             rsp_valid,
    output logic [FN_W-1:0]  rsp_frame,
    output xw_attr_t         rsp_attr,
    output logic             rsp_fault,
    output logic             rsp_perm
);
    xw_state_e        state;
    logic [VPN_W-1:0] vpn_q;
    logic             wr_q;
    logic [FN_W-1:0]  lvl_base_q;
    logic [FN_W-1:0]  frame_q;
    xw_attr_t         attr_q;
    logic             fault_q;
    logic             perm_q;
    logic [IDX_W-1:0] idx;
    logic             perm_ok;

    // Pick the index for the level being read and whether access is allowed.
    always_comb begin
        idx     = (state == ST_TBL_REQ) ? vpn_q[IDX_W-1:0] : vpn_q[VPN_W-1:IDX_W];
        perm_ok = wr_q ? dec_attr.wr : dec_attr.rd;
    end

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            vpn_q      <= '0;
            wr_q       <= 1'b0;
            lvl_base_q <= '0;
            frame_q    <= '0;
            attr_q     <= '0;
            fault_q    <= 1'b0;
            perm_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q      <= req_vpn;
                        wr_q       <= req_write;
                        lvl_base_q <= base_frame;
                        frame_q    <= '0;
                        attr_q     <= '0;
                        perm_q     <= 1'b0;
                        fault_q    <= !base_valid;
                        state      <= base_valid ? ST_DIR_REQ : ST_DONE;
                    end
                end
                ST_DIR_REQ: state <= ST_DIR_WAIT;
                ST_DIR_WAIT: begin
                    if (mem_resp_valid) begin
                        if (dec_zero || !dec_next) begin
                            fault_q <= 1'b1;
                            state   <= ST_DONE;
                        end else begin
                            lvl_base_q <= dec_frame;
                            state      <= ST_TBL_REQ;
                        end
                    end
                end
                ST_TBL_REQ: state <= ST_TBL_WAIT;
                ST_TBL_WAIT: begin
                    if (mem_resp_valid) begin
                        if (dec_zero) begin
                            fault_q <= 1'b1;
                        end else if (!perm_ok) begin
                            fault_q <= 1'b1;
                            perm_q  <= 1'b1;
                        end else begin
                            frame_q <= dec_frame;
                            attr_q  <= dec_attr;
                        end
                        state <= ST_DONE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port and the result outputs from state.
    always_comb begin
        busy          = (state != ST_IDLE);
        mem_req_valid = (state == ST_DIR_REQ) || (state == ST_TBL_REQ);
        mem_req_addr  = {lvl_base_q, idx, 2'b00};
        rsp_valid     = (state == ST_DONE);
        rsp_frame     = frame_q;
        rsp_attr      = attr_q;
        rsp_fault     = fault_q;
        rsp_perm      = perm_q;
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !rsp_valid)); // R11
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)); // R11
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_frame == '0 && rsp_attr == '0)); // R5
    AST_PERM_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm) |-> rsp_fault); // R7
endmodule

// File: rtl/xlat_walker.sv
// Two-level page table walker top: base store, entry decoder, sequencer.
// Assumes one walk at a time and a memory port with one read in flight.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int ASID_W  = 7,
    parameter int PA_BITS = 34,
    localparam int FN_W   = PA_BITS - PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_sel_data,
    input  logic [31:0]        cfg_wdata,
    input  logic               req_valid,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic [31:0]        req_va,
    input  logic               req_write,
    output logic               busy,
    output logic               mem_req_valid,
    output logic [PA_BITS-1:0] mem_req_addr,
    input  logic               mem_resp_valid,
    input  logic [31:0]        mem_resp_data,
    output logic               rsp_valid,
    output logic [FN_W-1:0]    rsp_frame,
    output logic               rsp_rd,
    output logic               rsp_wr,
    output logic               rsp_ns,
    output logic               rsp_fault,
    output logic               rsp_perm
);
    logic [FN_W-1:0] base_frame;
    logic            base_valid;
    logic            dec_zero;
    logic            dec_next;
    xw_attr_t        dec_attr;
    logic [FN_W-1:0] dec_frame;
    xw_attr_t        out_attr;

    xw_base_table #(.ASID_W(ASID_W), .FN_W(FN_W)) u_base (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_sel_data (cfg_sel_data),
        .cfg_wdata    (cfg_wdata),
        .lk_asid      (req_asid),
        .lk_base      (base_frame),
        .lk_valid     (base_valid)
    );

    xw_entry_decode #(.FN_W(FN_W)) u_dec (
        .entry    (mem_resp_data),
        .is_zero  (dec_zero),
        .has_next (dec_next),
        .attr     (dec_attr),
        .frame    (dec_frame)
    );

    xw_walk_fsm #(.FN_W(FN_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vpn        (req_va[31:PAGE_SHIFT]),
        .req_write      (req_write),
        .base_valid     (base_valid),
        .base_frame     (base_frame),
        .busy           (busy),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .dec_zero       (dec_zero),
        .dec_next       (dec_next),
        .dec_attr       (dec_attr),
        .dec_frame      (dec_frame),
        .rsp_valid      (rsp_valid),
        .rsp_frame      (rsp_frame),
        .rsp_attr       (out_attr),
        .rsp_fault      (rsp_fault),
        .rsp_perm       (rsp_perm)
    );

    // Flatten the attribute struct onto plain ports.
    always_comb begin
        rsp_rd = out_attr.rd;
        rsp_wr = out_attr.wr;
        rsp_ns = out_attr.ns;
    end

    AST_NO_REQ_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req_valid && !rsp_valid)); // R1
endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PA_BITS    = 34;
    localparam int FN_W       = PA_BITS - 12;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_wr = 1'b0;
    logic               cfg_sel_data = 1'b0;
    logic [31:0]        cfg_wdata = '0;
    logic               req_valid = 1'b0;
    logic [6:0]         req_asid = '0;
    logic [31:0]        req_va = '0;
    logic               req_write = 1'b0;
    logic               busy;
    logic               mem_req_valid;
    logic [PA_BITS-1:0] mem_req_addr;
    logic               mem_resp_valid = 1'b0;
    logic [31:0]        mem_resp_data = '0;
    logic               rsp_valid;
    logic [FN_W-1:0]    rsp_frame;
    logic               rsp_rd, rsp_wr, rsp_ns, rsp_fault, rsp_perm;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    xlat_walker #(.ASID_W(7), .PA_BITS(PA_BITS)) u_xlat_walker (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel_data(cfg_sel_data),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_asid(req_asid),
        .req_va(req_va), .req_write(req_write), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .rsp_valid(rsp_valid), .rsp_frame(rsp_frame), .rsp_rd(rsp_rd),
        .rsp_wr(rsp_wr), .rsp_ns(rsp_ns), .rsp_fault(rsp_fault), .rsp_perm(rsp_perm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: sparse words, answers mem_lat falling edges after a request.
    logic [31:0]        mem_words [logic [PA_BITS-1:0]];
    int                 mem_lat = 1;
    int                 mem_req_cnt = 0;
    logic [PA_BITS-1:0] addr_log [4];
    logic [PA_BITS-1:0] pend_addr = '0;
    int                 wait_cnt = 0;

    function automatic logic [31:0] mem_rd(input logic [PA_BITS-1:0] a);
        if (mem_words.exists(a)) return mem_words[a];
        return 32'd0;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = mem_rd(pend_addr);
                end
            end
            if (mem_req_valid) begin
                pend_addr = mem_req_addr;
                wait_cnt  = mem_lat;
                addr_log[mem_req_cnt % 4] = mem_req_addr;
                mem_req_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel_data, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel_data = sel_data; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    int                 w_cyc;
    int                 w_nreq;
    int                 w_first;
    logic [FN_W-1:0]    w_frame;
    logic [2:0]         w_attr;
    logic               w_fault, w_perm, w_busy_mid, w_busy_after;

    // One walk; when hold_other is set, a second request is held while busy.
    task automatic walk(input logic [6:0] asid, input logic [31:0] va, input bit wr,
                        input bit hold_other);
        int n;
        w_first = mem_req_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_asid = asid; req_va = va; req_write = wr;
        @(negedge clk);
        req_valid = hold_other;
        if (hold_other) begin req_va = 32'h8000_0000; req_write = ~wr; end
        n = 1;
        w_busy_mid = busy;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        w_cyc   = n;
        w_frame = rsp_frame;
        w_attr  = {rsp_rd, rsp_wr, rsp_ns};
        w_fault = rsp_fault;
        w_perm  = rsp_perm;
        w_nreq  = mem_req_cnt - w_first;
        @(negedge clk);
        w_busy_after = busy;
        chk("R10 rsp_valid drops", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic test_reset();
        chk("R1 busy", {63'd0, busy}, 64'd0);
        chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk("R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
        walk(7'd7, 32'h4080_5000, 1'b0, 1'b0);
        chk("R3 unprogrammed fault", {62'd0, w_fault, w_perm}, 64'd2);
        chk("R3 no memory read", w_nreq, 0);
        chk("R3 latency", w_cyc, 1);
        chk("R5 fault frame zero", {39'd0, w_frame, w_attr}, 64'd0);
    endtask

    task automatic test_success();
        mem_lat = 1;
        walk(7'd5, 32'h4080_5000, 1'b0, 1'b0);
        chk("R8 frame", w_frame, 22'h0ABCDE);
        chk("R8 attrs", w_attr, 3'b111);
        chk("R8 no fault", w_fault, 0);
        chk("R4 dir addr", addr_log[w_first % 4], 34'h123408);
        chk("R4 tbl addr", addr_log[(w_first + 1) % 4], 34'h456014);
        chk("R12 two reads", w_nreq, 2);
        chk("R10 latency L1", w_cyc, 5);
        chk("R11 busy during", w_busy_mid, 1);
        chk("R11 busy after", w_busy_after, 0);
        mem_lat = 3;
        walk(7'd5, 32'h4080_5000, 1'b1, 1'b0);
        chk("R10 latency L3", w_cyc, 9);
        chk("R8 frame L3", w_frame, 22'h0ABCDE);
        mem_lat = 1;
    endtask

    task automatic test_mask_perm();
        walk(7'd5, 32'h4080_6000, 1'b0, 1'b0);
        chk("R9 pte masked frame", w_frame, 22'h012345);
        chk("R8 attrs rd only", w_attr, 3'b100);
        walk(7'd5, 32'h4080_6000, 1'b1, 1'b0);
        chk("R7 write perm fault", {62'd0, w_fault, w_perm}, 64'd3);
        chk("R5 perm fault frame zero", {39'd0, w_frame, w_attr}, 64'd0);
        walk(7'd9, 32'h0000_0000, 1'b1, 1'b0);
        chk("R9 masked base dir addr", addr_log[w_first % 4], 34'h200000);
        chk("R9 masked pde tbl addr", addr_log[(w_first + 1) % 4], 34'h300000);
        chk("R8 write ok frame", w_frame, 22'h000777);
        chk("R8 write ok attrs", w_attr, 3'b010);
        walk(7'd9, 32'h0000_0000, 1'b0, 1'b0);
        chk("R7 read perm fault", {62'd0, w_fault, w_perm}, 64'd3);
    endtask

    task automatic test_faults();
        walk(7'd5, 32'h8000_0000, 1'b0, 1'b0);
        chk("R5 zero pde fault", {62'd0, w_fault, w_perm}, 64'd2);
        chk("R5 one read", w_nreq, 1);
        chk("R10 dir fault latency", w_cyc, 3);
        walk(7'd5, 32'hC000_0000, 1'b0, 1'b0);
        chk("R5 no-next pde fault", {62'd0, w_fault, w_perm}, 64'd2);
        chk("R5 no-next one read", w_nreq, 1);
        walk(7'd5, 32'h4080_7000, 1'b0, 1'b0);
        chk("R6 zero pte fault", {62'd0, w_fault, w_perm}, 64'd2);
        chk("R6 two reads", w_nreq, 2);
    endtask

    task automatic test_select();
        cfg_write(1'b0, 32'h0000_0014);
        cfg_write(1'b0, 32'hFFFF_FF95);
        cfg_write(1'b1, 32'h0000_0123);
        walk(7'd21, 32'h4080_5000, 1'b0, 1'b0);
        chk("R2 latest selection programmed", w_frame, 22'h0ABCDE);
        walk(7'd20, 32'h4080_5000, 1'b0, 1'b0);
        chk("R2 earlier selection untouched", {62'd0, w_fault, w_perm}, 64'd2);
        walk(7'd5, 32'h4080_5000, 1'b0, 1'b0);
        chk("R2 other identifier kept", w_frame, 22'h0ABCDE);
    endtask

    task automatic test_busy_ignore();
        walk(7'd5, 32'h4080_5000, 1'b0, 1'b1);
        chk("R11 held request ignored frame", w_frame, 22'h0ABCDE);
        chk("R11 held request ignored reads", w_nreq, 2);
        chk("R11 busy after", w_busy_after, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mem_words[34'h123408] = 32'hF000_0456;
        mem_words[34'h456014] = 32'hE00A_BCDE;
        mem_words[34'h456018] = 32'h8FC1_2345;
        mem_words[34'h123C00] = 32'hE000_0999;
        mem_words[34'h200000] = 32'h10C0_0300;
        mem_words[34'h300000] = 32'h4000_0777;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        cfg_write(1'b0, 32'h0000_0005);
        cfg_write(1'b1, 32'hE000_0123);
        cfg_write(1'b0, 32'h0000_0009);
        cfg_write(1'b1, 32'hE0C0_0200);
        test_success();
        test_mask_perm();
        test_faults();
        test_select();
        test_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule